// File: doc/BRIEF.md
# ADC Sample Sequencer FIFO Bank

This block is the digital front end that sits between an analog converter and a processor bus. It holds four sample sequencers. Each sequencer owns a 16-entry result FIFO, a sample-mux word, a control word and a status word that shows the FIFO's raw read and write pointers with its empty and full flags. A conversion strobe delivers one result word alongside it. When sequencer 0 is active, that result is pushed into sequencer 0's FIFO.

Software works through a small register bus with a single-cycle write strobe and a read strobe whose data appears one cycle later. Reading a sequencer's FIFO data register pops one result. Global registers hold the active-sequencer bits, a raw interrupt word and its mask, sticky overflow and underflow bits, a trigger-source selector and a priority word. The interrupt line is the OR of raw status ANDed with mask.

Sequencer windows start at 0x40 and are 0x20 bytes apart. Within a window, the sample mux is at +0x00, control at +0x04, FIFO data at +0x08 and FIFO status at +0x0C. The global registers are active at 0x00, raw interrupt at 0x04, mask at 0x08, masked interrupt at 0x0C (read-only), overflow at 0x10, underflow at 0x14, trigger source at 0x18 and priority at 0x1C.

Top module: `adc_seq_fifo_bank`

## Requirements
- R1: After reset, every FIFO status word reads 0x100, with both pointers 0 and empty set. Every other register reads 0, and `irq` is low.
- R2: The FIFO status word carries the read pointer in bits 3:0, the write pointer in bits 7:4, empty in bit 8 and full in bit 12. A push stores the word at the write pointer, advances it and clears empty. A pop advances the read pointer and clears full. Results come out in push order.
- R3: The FIFO becomes full when a push leaves the write pointer equal to the read pointer. A push to a full FIFO is discarded, leaving the pointers unchanged, and sets that sequencer's bit in the overflow register.
- R4: A pop from an empty FIFO returns the entry at the read pointer, leaves the pointers unchanged and sets that sequencer's bit in the underflow register.
- R5: A conversion strobe is accepted only while active-register bit 0 is set. An accepted strobe pushes `conv_data` into sequencer 0's FIFO and sets raw interrupt bit 0. The active register keeps 4 bits.
- R6: `irq` is high exactly when raw status AND mask is nonzero. Offset 0x0C reads that AND.
- R7: Raw interrupt, overflow and underflow bits are cleared by writing 1. A set event in the same cycle as the clear wins.
- R8: The sample-mux register stores only the bits under 0x33333333. The control register stores all 32 bits.
- R9: The trigger-source register holds one 4-bit code per sequencer, with sequencer n at bits 4n+3:4n. The legal codes are 0 (software), 1 (comparator), 4 (external pin), 5 (timer) and 6, 7, 8 (PWM generators 0 to 2). A field written with any other code keeps its old value.
- R10: The priority register stores only the bits under 0x3333.
- R11: When a push and a pop hit sequencer 0's FIFO in the same cycle, both are judged on the state before that cycle. A full FIFO drops the push while the pop proceeds. An empty FIFO underflows the pop while the push proceeds. When both succeed, the flags are unchanged.
- R12: Read data appears on `bus_rdata` the cycle after `bus_rd` and holds until the next read. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (FIFO data read pops) |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| conv_trig | input | 1 | Conversion-complete strobe |
| conv_data | input | 12 | Conversion result that comes with the strobe |
| irq | output | 1 | Interrupt, raw status AND mask |

## Verification
A conversion strobe and a software pop of sequencer 0's FIFO can land in the same cycle. The bench provokes this deliberately at both extremes: a full FIFO, where the push must drop while the pop succeeds, and an empty FIFO, where the pop must underflow while the push lands. The random phase also produces the collision often with mid-level occupancy. Each outcome is judged against a bench model that evaluates both operations on the pre-cycle pointers, then compares the pointers, the flags, the sticky bits and the data popped afterwards.

// File: rtl/adc_sfb_pkg.sv
package adc_sfb_pkg;
    localparam int NUM_SEQ   = 4;
    localparam int FIFO_SLOTS = 16;
    localparam int SAMPLE_W  = 12;
    localparam int ADDR_W    = 8;

    localparam logic [ADDR_W-1:0] OFS_ACTIVE = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_MIS    = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_OVF    = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_UNF    = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_SRC    = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_PRIO   = 8'h1C;
    localparam logic [ADDR_W-1:0] WIN_BASE   = 8'h40;
    localparam int                WIN_SPAN   = 32;

    localparam logic [4:0] SUB_MUX  = 5'h00;
    localparam logic [4:0] SUB_CTL  = 5'h04;
    localparam logic [4:0] SUB_DATA = 5'h08;
    localparam logic [4:0] SUB_STAT = 5'h0C;

    localparam logic [31:0] MUX_KEEP  = 32'h3333_3333;
    localparam logic [15:0] PRIO_KEEP = 16'h3333;

    typedef enum logic [3:0] {
        SRC_SOFT  = 4'd0,
        SRC_CMP   = 4'd1,
        SRC_PIN   = 4'd4,
        SRC_TIMER = 4'd5,
        SRC_PWM0  = 4'd6,
        SRC_PWM1  = 4'd7,
        SRC_PWM2  = 4'd8
    } trig_src_e;

    function automatic logic src_code_legal(input logic [3:0] code);
        case (code)
            SRC_SOFT, SRC_CMP, SRC_PIN, SRC_TIMER,
            SRC_PWM0, SRC_PWM1, SRC_PWM2: return 1'b1;
            default:                      return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/adc_trig_gate.sv
module adc_trig_gate #(
    parameter int NSEQ = 4
) (
    input  logic            trig,
    input  logic [NSEQ-1:0] active,
    output logic [NSEQ-1:0] push
);
    // Only the first sequencer is fed by the conversion strobe.
    always_comb begin
        push    = '0;
        push[0] = trig && active[0];
    end
endmodule

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 12,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] rd_word,
    output logic [PW-1:0] head,
    output logic [PW-1:0] tail,
    output logic          empty,
    output logic          full,
    output logic          ovf_evt,
    output logic          unf_evt
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            head;
        logic [PW-1:0]            tail;
        logic                     empty;
        logic                     full;
    } fifo_t;

    fifo_t s_d, s_q;
    logic  push_ok, pop_ok;

    always_comb begin
        s_d     = s_q;
        push_ok = push && !s_q.full;
        pop_ok  = pop && !s_q.empty;
        if (push_ok) begin
            s_d.mem[s_q.head] = push_data;
            s_d.head          = s_q.head + PW'(1);
        end
        if (pop_ok) begin
            s_d.tail = s_q.tail + PW'(1);
        end
        if (push_ok && !pop_ok) begin
            s_d.empty = 1'b0;
            s_d.full  = (s_d.head == s_q.tail);
        end else if (pop_ok && !push_ok) begin
            s_d.full  = 1'b0;
            s_d.empty = (s_d.tail == s_q.head);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.empty <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_word = s_q.mem[s_q.tail];
    assign head    = s_q.head;
    assign tail    = s_q.tail;
    assign empty   = s_q.empty;
    assign full    = s_q.full;
    assign ovf_evt = push && s_q.full;
    assign unf_evt = pop && s_q.empty;

    a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));
    a_r3_drop_keeps_head: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> $stable(head));
    a_r4_empty_pop_keeps_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> $stable(tail));
    a_r11_both_keep_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty && !full) |=> ($stable(empty) && $stable(full)));
endmodule

// File: rtl/adc_seq_fifo_bank.sv
module adc_seq_fifo_bank
    import adc_sfb_pkg::*;
#(
    parameter int NSEQ  = NUM_SEQ,
    parameter int DEPTH = FIFO_SLOTS,
    parameter int DW    = SAMPLE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              conv_trig,
    input  logic [DW-1:0]     conv_data,
    output logic              irq
);
    localparam int PW = $clog2(DEPTH);
    localparam int SW = (NSEQ > 1) ? $clog2(NSEQ) : 1;

    typedef struct packed {
        logic [NSEQ-1:0]         act;
        logic [NSEQ-1:0]         raw;
        logic [NSEQ-1:0]         msk;
        logic [NSEQ-1:0]         ovf;
        logic [NSEQ-1:0]         unf;
        logic [4*NSEQ-1:0]       src;
        logic [4*NSEQ-1:0]       prio;
        logic [NSEQ-1:0][31:0]   smux;
        logic [NSEQ-1:0][31:0]   ctl;
        logic [31:0]             rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [NSEQ-1:0]          push_v, pop_v, ovf_e, unf_e, f_emp, f_ful;
    logic [NSEQ-1:0][PW-1:0]  f_head, f_tail;
    logic [NSEQ-1:0][DW-1:0]  f_word;
    logic [NSEQ-1:0][31:0]    f_stat;

    logic [ADDR_W-1:0] win_off;
    logic              in_win;
    logic [SW-1:0]     win_idx;
    logic [4:0]        sub;

    assign win_off = bus_addr - WIN_BASE;
    assign in_win  = (bus_addr >= WIN_BASE) && ({1'b0, win_off} < 9'(NSEQ * WIN_SPAN));
    assign win_idx = win_off[5 +: SW];
    assign sub     = bus_addr[4:0];

    adc_trig_gate #(.NSEQ(NSEQ)) u_gate (
        .trig   (conv_trig),
        .active (r_q.act),
        .push   (push_v)
    );

    for (genvar g = 0; g < NSEQ; g++) begin : g_seq
        assign pop_v[g] = bus_rd && in_win && (win_idx == SW'(g)) && (sub == SUB_DATA);

        adc_seq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push_v[g]),
            .push_data (conv_data),
            .pop       (pop_v[g]),
            .rd_word   (f_word[g]),
            .head      (f_head[g]),
            .tail      (f_tail[g]),
            .empty     (f_emp[g]),
            .full      (f_ful[g]),
            .ovf_evt   (ovf_e[g]),
            .unf_evt   (unf_e[g])
        );

        assign f_stat[g] = {19'd0, f_ful[g], 3'd0, f_emp[g], 4'(f_head[g]), 4'(f_tail[g])};
    end

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            if (in_win) begin
                case (sub)
                    SUB_MUX: r_d.smux[win_idx] = bus_wdata & MUX_KEEP;
                    SUB_CTL: r_d.ctl[win_idx]  = bus_wdata;
                    default: ;
                endcase
            end else begin
                case (bus_addr)
                    OFS_ACTIVE: r_d.act  = bus_wdata[NSEQ-1:0];
                    OFS_RAW:    r_d.raw  = r_q.raw & ~bus_wdata[NSEQ-1:0];
                    OFS_MASK:   r_d.msk  = bus_wdata[NSEQ-1:0];
                    OFS_OVF:    r_d.ovf  = r_q.ovf & ~bus_wdata[NSEQ-1:0];
                    OFS_UNF:    r_d.unf  = r_q.unf & ~bus_wdata[NSEQ-1:0];
                    OFS_PRIO:   r_d.prio = bus_wdata[4*NSEQ-1:0] & PRIO_KEEP[4*NSEQ-1:0];
                    OFS_SRC: begin
                        for (int n = 0; n < NSEQ; n++) begin
                            if (src_code_legal(bus_wdata[4*n +: 4])) begin
                                r_d.src[4*n +: 4] = bus_wdata[4*n +: 4];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
        // Set events take precedence over same-cycle clears.
        r_d.raw[0] = r_d.raw[0] | push_v[0];
        r_d.ovf    = r_d.ovf | ovf_e;
        r_d.unf    = r_d.unf | unf_e;

        if (bus_rd) begin
            r_d.rdata = '0;
            if (in_win) begin
                case (sub)
                    SUB_MUX:  r_d.rdata = r_q.smux[win_idx];
                    SUB_CTL:  r_d.rdata = r_q.ctl[win_idx];
                    SUB_DATA: r_d.rdata = 32'(f_word[win_idx]);
                    SUB_STAT: r_d.rdata = f_stat[win_idx];
                    default:  ;
                endcase
            end else begin
                case (bus_addr)
                    OFS_ACTIVE: r_d.rdata = 32'(r_q.act);
                    OFS_RAW:    r_d.rdata = 32'(r_q.raw);
                    OFS_MASK:   r_d.rdata = 32'(r_q.msk);
                    OFS_MIS:    r_d.rdata = 32'(r_q.raw & r_q.msk);
                    OFS_OVF:    r_d.rdata = 32'(r_q.ovf);
                    OFS_UNF:    r_d.rdata = 32'(r_q.unf);
                    OFS_SRC:    r_d.rdata = 32'(r_q.src);
                    OFS_PRIO:   r_d.rdata = 32'(r_q.prio);
                    default:    ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata = r_q.rdata;
    assign irq       = |(r_q.raw & r_q.msk);

    a_r5_idle_trigger_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_trig && !r_q.act[0]) |=> $stable(f_head[0]));
    a_r7_overflow_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_e[0] |=> r_q.ovf[0]);
    a_r7_underflow_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_e != '0) |=> ((r_q.unf & $past(unf_e)) == $past(unf_e)));
    a_r12_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/adc_seq_fifo_bank_tb.sv
`timescale 1ns/1ps
module adc_seq_fifo_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, conv_trig = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [11:0] conv_data = '0;
    logic        irq;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    adc_seq_fifo_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .conv_trig(conv_trig), .conv_data(conv_data), .irq(irq)
    );

    // Bench model
    logic [11:0] m_mem [4][16];
    logic [3:0]  m_head [4];
    logic [3:0]  m_tail [4];
    logic        m_emp [4];
    logic        m_ful [4];
    logic [3:0]  m_act, m_raw, m_msk, m_ovf, m_unf;
    logic [15:0] m_src, m_prio;
    logic [31:0] m_smux [4];
    logic [31:0] m_ctl [4];

    task automatic model_reset();
        for (int n = 0; n < 4; n++) begin
            for (int k = 0; k < 16; k++) m_mem[n][k] = '0;
            m_head[n] = '0; m_tail[n] = '0; m_emp[n] = 1'b1; m_ful[n] = 1'b0;
            m_smux[n] = '0; m_ctl[n] = '0;
        end
        m_act = '0; m_raw = '0; m_msk = '0; m_ovf = '0; m_unf = '0;
        m_src = '0; m_prio = '0;
    endtask

    function automatic logic legal_code(input logic [3:0] c);
        return (c == 4'd0) || (c == 4'd1) || (c >= 4'd4 && c <= 4'd8);
    endfunction

    function automatic logic [31:0] stat_word(input int n);
        return {19'd0, m_ful[n], 3'd0, m_emp[n], m_head[n], m_tail[n]};
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int n;
        if (a >= 8'h40 && a < 8'hC0) begin
            n = int'((a - 8'h40) >> 5);
            case (a[4:0])
                5'h00:   return m_smux[n];
                5'h04:   return m_ctl[n];
                5'h08:   return {20'd0, m_mem[n][m_tail[n]]};
                5'h0C:   return stat_word(n);
                default: return 32'd0;
            endcase
        end
        case (a)
            8'h00:   return {28'd0, m_act};
            8'h04:   return {28'd0, m_raw};
            8'h08:   return {28'd0, m_msk};
            8'h0C:   return {28'd0, m_raw & m_msk};
            8'h10:   return {28'd0, m_ovf};
            8'h14:   return {28'd0, m_unf};
            8'h18:   return {16'd0, m_src};
            8'h1C:   return {16'd0, m_prio};
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_update(input bit wr, input bit rd, input logic [7:0] a,
                                input logic [31:0] wd, input bit tg, input logic [11:0] td);
        bit acc, in_win, pu, po, apu, apo;
        int pn;
        logic [3:0] oe, ue;
        acc    = tg && m_act[0];
        in_win = (a >= 8'h40 && a < 8'hC0);
        pn     = in_win ? int'((a - 8'h40) >> 5) : -1;
        oe = '0; ue = '0;
        for (int f = 0; f < 4; f++) begin
            pu  = (f == 0) && acc;
            po  = rd && in_win && (a[4:0] == 5'h08) && (pn == f);
            apu = pu && !m_ful[f];
            apo = po && !m_emp[f];
            oe[f] = pu && m_ful[f];
            ue[f] = po && m_emp[f];
            if (apu) begin
                m_mem[f][m_head[f]] = td;
                m_head[f] = m_head[f] + 4'd1;
            end
            if (apo) m_tail[f] = m_tail[f] + 4'd1;
            if (apu && !apo) begin m_emp[f] = 1'b0; m_ful[f] = (m_head[f] == m_tail[f]); end
            else if (apo && !apu) begin m_ful[f] = 1'b0; m_emp[f] = (m_head[f] == m_tail[f]); end
        end
        if (wr) begin
            if (in_win) begin
                if (a[4:0] == 5'h00) m_smux[pn] = wd & 32'h3333_3333;
                if (a[4:0] == 5'h04) m_ctl[pn] = wd;
            end else begin
                case (a)
                    8'h00: m_act = wd[3:0];
                    8'h04: m_raw = m_raw & ~wd[3:0];
                    8'h08: m_msk = wd[3:0];
                    8'h10: m_ovf = m_ovf & ~wd[3:0];
                    8'h14: m_unf = m_unf & ~wd[3:0];
                    8'h1C: m_prio = wd[15:0] & 16'h3333;
                    8'h18: for (int n = 0; n < 4; n++)
                               if (legal_code(wd[4*n +: 4])) m_src[4*n +: 4] = wd[4*n +: 4];
                    default: ;
                endcase
            end
        end
        m_raw[0] = m_raw[0] | acc;
        m_ovf = m_ovf | oe;
        m_unf = m_unf | ue;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One cycle: inputs driven at a falling edge, checked at the next falling edge.
    task automatic step(input bit wr, input bit rd, input logic [7:0] a, input logic [31:0] wd,
                        input bit tg, input logic [11:0] td, input string req);
        logic [31:0] exp_rd;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        conv_trig = tg; conv_data = td;
        exp_rd = model_read(a);
        model_update(wr, rd, a, wd, tg, td);
        @(negedge clk);
        if (rd) chk(bus_rdata == exp_rd, req, bus_rdata, exp_rd);
        chk(irq == |(m_raw & m_msk), "R6", {31'd0, irq}, {31'd0, |(m_raw & m_msk)});
        bus_wr = 1'b0; bus_rd = 1'b0; conv_trig = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d, input string req);
        step(1'b1, 1'b0, a, d, 1'b0, '0, req);
    endtask
    task automatic rd_reg(input logic [7:0] a, input string req);
        step(1'b0, 1'b1, a, '0, 1'b0, '0, req);
    endtask
    task automatic trig(input logic [11:0] d, input string req);
        step(1'b0, 1'b0, 8'h00, '0, 1'b1, d, req);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : main
        logic [31:0] held;
        int r;
        model_reset();
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int n = 0; n < 4; n++) rd_reg(8'h4C + 8'(n * 32), "R1");
        rd_reg(8'h00, "R1");
        rd_reg(8'h04, "R1");
        chk(irq == 1'b0, "R1", {31'd0, irq}, 32'd0);

        // R8 mux and control storage
        wr_reg(8'h80, 32'hFFFF_FFFF, "R8");
        rd_reg(8'h80, "R8");
        wr_reg(8'h64, 32'hDEAD_BEEF, "R8");
        rd_reg(8'h64, "R8");

        // R9 trigger source codes: field 2 illegal (0xF) keeps 0
        wr_reg(8'h18, 32'h0000_8F54, "R9");
        rd_reg(8'h18, "R9");
        chk(bus_rdata == 32'h0000_8054, "R9", bus_rdata, 32'h0000_8054);
        wr_reg(8'h18, 32'h0000_2323, "R9");
        rd_reg(8'h18, "R9");

        // R10 priority
        wr_reg(8'h1C, 32'hFFFF_FFFF, "R10");
        rd_reg(8'h1C, "R10");

        // R5 strobe ignored while inactive
        trig(12'h123, "R5");
        rd_reg(8'h4C, "R5");
        chk(bus_rdata == 32'h100, "R5", bus_rdata, 32'h100);
        rd_reg(8'h04, "R5");
        wr_reg(8'h00, 32'hFF, "R5");
        rd_reg(8'h00, "R5");

        // R2 ordering and pointer fields
        trig(12'hA01, "R2"); trig(12'hA02, "R2"); trig(12'hA03, "R2");
        rd_reg(8'h4C, "R2");
        chk(bus_rdata == 32'h30, "R2", bus_rdata, 32'h30);
        rd_reg(8'h48, "R2");
        chk(bus_rdata == 32'hA01, "R2", bus_rdata, 32'hA01);
        rd_reg(8'h48, "R2"); rd_reg(8'h48, "R2");
        rd_reg(8'h4C, "R2");
        chk(bus_rdata == 32'h133, "R2", bus_rdata, 32'h133);

        // R3 fill to full, then a dropped push
        for (int k = 0; k < 16; k++) trig(12'(12'h500 + k), "R3");
        rd_reg(8'h4C, "R3");
        chk(bus_rdata == 32'h1033, "R3", bus_rdata, 32'h1033);
        trig(12'hEEE, "R3");
        rd_reg(8'h4C, "R3");
        rd_reg(8'h10, "R3");
        chk(bus_rdata == 32'h1, "R3", bus_rdata, 32'h1);

        // R11 collision at full: push dropped, pop proceeds
        wr_reg(8'h10, 32'hF, "R7");
        step(1'b0, 1'b1, 8'h48, '0, 1'b1, 12'hBBB, "R11");
        rd_reg(8'h4C, "R11");
        rd_reg(8'h10, "R11");
        chk(bus_rdata == 32'h1, "R11", bus_rdata, 32'h1);
        for (int k = 0; k < 15; k++) rd_reg(8'h48, "R2");
        rd_reg(8'h4C, "R11");
        // R11 collision at empty: pop underflows, push lands
        step(1'b0, 1'b1, 8'h48, '0, 1'b1, 12'hCCC, "R11");
        rd_reg(8'h14, "R11");
        rd_reg(8'h4C, "R11");
        rd_reg(8'h48, "R11");
        chk(bus_rdata == 32'hCCC, "R11", bus_rdata, 32'hCCC);

        // R4 underflow on an untouched FIFO
        rd_reg(8'hA8, "R4");
        rd_reg(8'hAC, "R4");
        rd_reg(8'h14, "R4");

        // R6 masking
        wr_reg(8'h08, 32'h1, "R6");
        chk(irq == 1'b1, "R6", {31'd0, irq}, 32'd1);
        rd_reg(8'h0C, "R6");
        wr_reg(8'h08, 32'h0, "R6");
        chk(irq == 1'b0, "R6", {31'd0, irq}, 32'd0);

        // R7 clear with simultaneous set: set wins
        step(1'b1, 1'b0, 8'h04, 32'hF, 1'b1, 12'h077, "R7");
        rd_reg(8'h04, "R7");
        wr_reg(8'h04, 32'hF, "R7");
        rd_reg(8'h04, "R7");
        wr_reg(8'h14, 32'hF, "R7");
        rd_reg(8'h14, "R7");

        // R12 unmapped read and hold
        rd_reg(8'h20, "R12");
        rd_reg(8'h1C, "R12");
        held = bus_rdata;
        step(1'b0, 1'b0, 8'h00, '0, 1'b0, '0, "R12");
        chk(bus_rdata == held, "R12", bus_rdata, held);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            bit tg;
            tg = ($urandom % 100) < 35;
            r  = int'($urandom % 100);
            d  = $urandom;
            if (r < 30) step(1'b0, 1'b1, 8'h48, '0, tg, 12'($urandom), "R11");
            else if (r < 38) begin
                a = 8'h48 + 8'(($urandom % 4) * 32);
                step(1'b0, 1'b1, a, '0, tg, 12'($urandom), "R4");
            end else if (r < 50) begin
                a = 8'h4C + 8'(($urandom % 4) * 32);
                step(1'b0, 1'b1, a, '0, tg, 12'($urandom), "R2");
            end else if (r < 65) begin
                case ($urandom % 8)
                    0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h10;
                    4: a = 8'h14; 5: a = 8'h18; 6: a = 8'h1C;
                    default: a = 8'h40 + 8'(($urandom % 8) * 4);
                endcase
                if (a == 8'h00 && ($urandom % 4) != 0) d = d | 32'h1;
                step(1'b1, 1'b0, a, d, tg, 12'($urandom), "R7");
            end else if (r < 85) begin
                a = 8'($urandom % 8'hC4);
                if (a[4:0] == 5'h08 && a >= 8'h40) a = a + 8'h4;
                step(1'b0, 1'b1, a, '0, tg, 12'($urandom), "R12");
            end else begin
                step(1'b0, 1'b0, 8'h00, '0, tg, 12'($urandom), "R5");
            end
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule